// File: doc/BRIEF.md
# Bitplane DMA Fetch Sequencer

This block decides, one memory slot at a time along a video scan line, whether a bitplane word is fetched in that slot and which plane it belongs to. A horizontal window opens when the slot counter reaches a programmed start position. The window closes only after the fetch group that is in progress when the slot counter reaches a programmed stop position has finished. A vertical window is opened and closed once per line by comparing the line counter with programmed first and last lines. Each slot position maps to a plane index through a fixed interleaved order. Low and high resolution use different orders. A slot whose plane index is not below the active plane count stays idle.

The surrounding video logic drives the slot and line counters and marks each line boundary with an end-of-line strobe. It also writes the four window registers through a small select/data port and supplies the DMA enable, the resolution mode and the plane count. The block returns a fetch strobe with a plane index, a pulse when a word group is complete, and a pulse at end of line that tells the pointer logic to add the modulo. All outputs are registered, so each one appears one clock after the slot or strobe that produced it.

Top module: `bpl_fetch_seq`

## Requirements
- R1: In low resolution (`hires_i`=0), slot bits [2:0] select the plane as 1→3, 2→5, 3→1, 5→2, 6→4, 7→0. Values 0 and 4 never fetch.
- R2: In high resolution (`hires_i`=1), slot bits [1:0] select the plane as 0→3, 1→1, 2→2, 3→0.
- R3: A slot whose mapped plane index is greater than or equal to `plane_cnt_i` does not fetch.
- R4: The horizontal window opens in the slot whose number equals the start register (select 0). That slot is included. Earlier slots of the line do not fetch.
- R5: When the slot number equals the stop register (select 1), the window stays open until a plane-0 fetch completes the group. It is closed from the following slot.
- R6: On an end-of-line strobe, the vertical window is set if `line_i` equals the first-line register (select 2) and cleared if it equals the last-line register (select 3). Clearing wins when both match. It does not change at any other time.
- R7: A fetch happens only when `dma_en_i` is 1 and both the horizontal and vertical windows are open.
- R8: The cycle after an end-of-line strobe, `modulo_o` is 1 exactly when at least one fetch happened since the previous strobe.
- R9: An end-of-line strobe closes the horizontal window, clears the stop mark and clears the fetched-this-line record. No fetch occurs in the strobe cycle.
- R10: `group_o` pulses together with each fetch of plane 0, and at no other time.
- R11: A register write takes effect from the next slot. After reset, all four registers are 0, both windows are closed and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | SLOT_W (9) | Horizontal slot number |
| line_i | input | LINE_W (9) | Line number, sampled on end of line |
| eol_i | input | 1 | End-of-line strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select: 0 start, 1 stop, 2 first line, 3 last line |
| wr_data_i | input | DATA_W (9) | Register write data |
| dma_en_i | input | 1 | Bitplane DMA enable |
| hires_i | input | 1 | 1 = high-resolution slot order |
| plane_cnt_i | input | 3 | Number of active planes |
| fetch_o | output | 1 | A bitplane word is fetched in the previous slot |
| plane_o | output | 3 | Plane index of that fetch |
| group_o | output | 1 | Word group complete |
| modulo_o | output | 1 | Apply the modulo at this line end |

## Verification
The assertions assume that `eol_i` arrives in a cycle of its own, with no slot meant to be processed in that cycle. They also assume that `plane_cnt_i`, `hires_i` and `dma_en_i` change only between slots, so that a registered output can be compared with the value these inputs had one cycle earlier. The stimulus keeps to this: every input is changed on the falling clock edge, and a line boundary is always a separate step with its own slot value. Window registers are rewritten only between lines. The one exception is a write that deliberately lands in the same cycle as a matching slot, used to show that the old value still applies.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

   localparam int PLANE_W = 3;

   typedef enum logic [1:0] {
      SEL_HSTART = 2'd0,
      SEL_HSTOP  = 2'd1,
      SEL_VFIRST = 2'd2,
      SEL_VLAST  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic               valid;
      logic [PLANE_W-1:0] plane;
   } slot_map_t;

   // Low-resolution order: eight slots per group, two of them left free.
   function automatic slot_map_t lores_map(input logic [2:0] pos);
      slot_map_t m;
      m.valid = 1'b1;
      case (pos)
         3'd1:    m.plane = 3'd3;
         3'd2:    m.plane = 3'd5;
         3'd3:    m.plane = 3'd1;
         3'd5:    m.plane = 3'd2;
         3'd6:    m.plane = 3'd4;
         3'd7:    m.plane = 3'd0;
         default: begin m.valid = 1'b0; m.plane = 3'd0; end
      endcase
      return m;
   endfunction

   // High-resolution order: four slots per group, all used.
   function automatic slot_map_t hires_map(input logic [1:0] pos);
      slot_map_t m;
      m.valid = 1'b1;
      case (pos)
         2'd0:    m.plane = 3'd3;
         2'd1:    m.plane = 3'd1;
         2'd2:    m.plane = 3'd2;
         default: m.plane = 3'd0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bpf_regs.sv
module bpf_regs #(
   parameter int SLOT_W = 9,
   parameter int LINE_W = 9,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [SLOT_W-1:0] hstart,
   output logic [SLOT_W-1:0] hstop,
   output logic [LINE_W-1:0] vfirst,
   output logic [LINE_W-1:0] vlast
);
   import bpf_pkg::*;

   if (DATA_W < SLOT_W || DATA_W < LINE_W) begin : g_bad_width
      $error("bpf_regs: DATA_W narrower than a register");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hstart <= '0;
         hstop  <= '0;
         vfirst <= '0;
         vlast  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_HSTART: hstart <= wr_data[SLOT_W-1:0];
            SEL_HSTOP:  hstop  <= wr_data[SLOT_W-1:0];
            SEL_VFIRST: vfirst <= wr_data[LINE_W-1:0];
            default:    vlast  <= wr_data[LINE_W-1:0];
         endcase
      end
   end

endmodule

// File: rtl/bpf_slot_map.sv
module bpf_slot_map #(
   parameter int SLOT_W  = 9,
   parameter bit HIRES_EN = 1'b1
) (
   input  logic                        hires,
   input  logic [SLOT_W-1:0]           slot,
   output logic                        valid,
   output logic [bpf_pkg::PLANE_W-1:0] plane
);
   import bpf_pkg::*;

   if (SLOT_W < 3) begin : g_bad_slot
      $error("bpf_slot_map: SLOT_W must cover one low-resolution group");
   end

   slot_map_t lo_m, sel_m;
   assign lo_m = lores_map(slot[2:0]);

   if (HIRES_EN) begin : g_both
      slot_map_t hi_m;
      assign hi_m  = hires_map(slot[1:0]);
      assign sel_m = hires ? hi_m : lo_m;
   end else begin : g_lores_only
      logic unused_hires;
      assign unused_hires = hires;
      assign sel_m = lo_m;
   end

   assign valid = sel_m.valid;
   assign plane = sel_m.plane;

endmodule

// File: rtl/bpf_window.sv
module bpf_window #(
   parameter int SLOT_W = 9,
   parameter int LINE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot,
   input  logic [LINE_W-1:0] line,
   input  logic              eol,
   input  logic [SLOT_W-1:0] hstart,
   input  logic [SLOT_W-1:0] hstop,
   input  logic [LINE_W-1:0] vfirst,
   input  logic [LINE_W-1:0] vlast,
   input  logic              grp_done,
   output logic              h_open,
   output logic              v_open
);
   logic h_q, last_q, last_eff;

   assign h_open   = h_q    | (!eol && slot == hstart);
   assign last_eff = last_q | (!eol && slot == hstop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q    <= 1'b0;
         last_q <= 1'b0;
         v_open <= 1'b0;
      end else if (eol) begin
         h_q    <= 1'b0;
         last_q <= 1'b0;
         v_open <= (v_open | (line == vfirst)) & (line != vlast);
      end else begin
         h_q    <= h_open & !(grp_done & last_eff);
         last_q <= last_eff;
      end
   end

   // R9
   eol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> (!h_q && !last_q));

   // R6
   vert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eol |=> $stable(v_open));

   // R5
   stop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!eol && grp_done && last_eff) |=> !h_q);

endmodule

// File: rtl/bpl_fetch_seq.sv
module bpl_fetch_seq #(
   parameter int SLOT_W   = 9,
   parameter int LINE_W   = 9,
   parameter bit HIRES_EN = 1'b1,
   localparam int DATA_W  = (SLOT_W > LINE_W) ? SLOT_W : LINE_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SLOT_W-1:0]           slot_i,
   input  logic [LINE_W-1:0]           line_i,
   input  logic                        eol_i,
   input  logic                        wr_en_i,
   input  logic [1:0]                  wr_sel_i,
   input  logic [DATA_W-1:0]           wr_data_i,
   input  logic                        dma_en_i,
   input  logic                        hires_i,
   input  logic [bpf_pkg::PLANE_W-1:0] plane_cnt_i,
   output logic                        fetch_o,
   output logic [bpf_pkg::PLANE_W-1:0] plane_o,
   output logic                        group_o,
   output logic                        modulo_o
);
   import bpf_pkg::*;

   if (LINE_W < 2) begin : g_bad_line
      $error("bpl_fetch_seq: LINE_W too small");
   end

   logic [SLOT_W-1:0]  hstart, hstop;
   logic [LINE_W-1:0]  vfirst, vlast;
   logic               map_valid, h_open, v_open;
   logic [PLANE_W-1:0] map_plane;
   logic               fetch_c, grp_c, fetched_q;

   bpf_regs #(.SLOT_W(SLOT_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
      .wr_data(wr_data_i), .hstart(hstart), .hstop(hstop),
      .vfirst(vfirst), .vlast(vlast)
   );

   bpf_slot_map #(.SLOT_W(SLOT_W), .HIRES_EN(HIRES_EN)) u_map (
      .hires(hires_i), .slot(slot_i), .valid(map_valid), .plane(map_plane)
   );

   bpf_window #(.SLOT_W(SLOT_W), .LINE_W(LINE_W)) u_win (
      .clk(clk), .rst_n(rst_n), .slot(slot_i), .line(line_i), .eol(eol_i),
      .hstart(hstart), .hstop(hstop), .vfirst(vfirst), .vlast(vlast),
      .grp_done(grp_c), .h_open(h_open), .v_open(v_open)
   );

   assign fetch_c = !eol_i && dma_en_i && v_open && h_open && map_valid
                    && (map_plane < plane_cnt_i);
   assign grp_c   = fetch_c && (map_plane == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_o   <= 1'b0;
         plane_o   <= '0;
         group_o   <= 1'b0;
         modulo_o  <= 1'b0;
         fetched_q <= 1'b0;
      end else begin
         fetch_o   <= fetch_c;
         plane_o   <= fetch_c ? map_plane : '0;
         group_o   <= grp_c;
         modulo_o  <= eol_i && fetched_q;
         fetched_q <= eol_i ? 1'b0 : (fetched_q | fetch_c);
      end
   end

   // R3
   plane_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |-> (plane_o < $past(plane_cnt_i)));

   // R10
   group_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      group_o |-> (fetch_o && plane_o == '0));

   // R7
   dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_o |-> ($past(dma_en_i) && !$past(eol_i)));

   // R8
   modulo_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      modulo_o |-> $past(eol_i));

   // R1
   lores_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_o && !$past(hires_i)) |-> ($past(slot_i[1:0]) != 2'd0));

endmodule

// File: tb/tb_bpl_fetch_seq.sv
module tb_bpl_fetch_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] slot_i = 9'd300;
   logic [8:0] line_i = '0;
   logic       eol_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_sel_i = '0;
   logic [8:0] wr_data_i = '0;
   logic       dma_en_i = 1'b0;
   logic       hires_i = 1'b0;
   logic [2:0] plane_cnt_i = 3'd6;
   logic       fetch_o, group_o, modulo_o;
   logic [2:0] plane_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bpl_fetch_seq dut (
      .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .line_i(line_i),
      .eol_i(eol_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .dma_en_i(dma_en_i), .hires_i(hires_i),
      .plane_cnt_i(plane_cnt_i), .fetch_o(fetch_o), .plane_o(plane_o),
      .group_o(group_o), .modulo_o(modulo_o)
   );

   // {hires, slot[7:0], fetch, plane[2:0], group}
   localparam logic [13:0] VEC [12] = '{
      {1'b0, 8'd9,  1'b1, 3'd3, 1'b0},
      {1'b0, 8'd10, 1'b1, 3'd5, 1'b0},
      {1'b0, 8'd11, 1'b1, 3'd1, 1'b0},
      {1'b0, 8'd12, 1'b0, 3'd0, 1'b0},
      {1'b0, 8'd13, 1'b1, 3'd2, 1'b0},
      {1'b0, 8'd14, 1'b1, 3'd4, 1'b0},
      {1'b0, 8'd15, 1'b1, 3'd0, 1'b1},
      {1'b0, 8'd16, 1'b0, 3'd0, 1'b0},
      {1'b1, 8'd20, 1'b1, 3'd3, 1'b0},
      {1'b1, 8'd21, 1'b1, 3'd1, 1'b0},
      {1'b1, 8'd22, 1'b1, 3'd2, 1'b0},
      {1'b1, 8'd23, 1'b1, 3'd0, 1'b1}
   };

   task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual fetch/plane/group/modulo=%b expected=%b", tag, act, exp);
      end
   endtask

   // Called at a falling edge; drives one cycle and checks its registered result.
   task automatic step(input bit e, input int ln, input int s, input bit we,
                       input int sel, input int d, input bit xf, input int xp,
                       input bit xg, input bit xm, input string tag);
      eol_i     = e;
      line_i    = 9'(ln);
      slot_i    = 9'(s);
      wr_en_i   = we;
      wr_sel_i  = 2'(sel);
      wr_data_i = 9'(d);
      @(negedge clk);
      eol_i   = 1'b0;
      wr_en_i = 1'b0;
      check({fetch_o, plane_o, group_o, modulo_o},
            {xf, 3'(xp), xg, xm}, tag);
   endtask

   task automatic wr(input int sel, input int d);
      step(0, 0, 300, 1, sel, d, 0, 0, 0, 0, "R11 write idle");
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check({fetch_o, plane_o, group_o, modulo_o}, 6'b0, "R11 reset outputs");
      rst_n = 1'b1;
      dma_en_i = 1'b1;
      @(negedge clk);
      wr(2, 3); wr(3, 100); wr(0, 8); wr(1, 255);
      step(1, 3, 300, 0, 0, 0, 0, 0, 0, 0, "R8 no fetch no modulo");
      step(0, 0, 8, 0, 0, 0, 0, 0, 0, 0, "R1 slot 0 idle");
      for (int i = 0; i < 12; i++) begin
         hires_i = VEC[i][13];
         step(0, 0, int'(VEC[i][12:5]), 0, 0, 0, VEC[i][4], int'(VEC[i][3:1]),
              VEC[i][0], 0, VEC[i][13] ? "R2 hires map" : "R1 lores map");
      end
      hires_i = 1'b0;
      step(1, 4, 300, 0, 0, 0, 0, 0, 0, 1, "R8 modulo after fetch");
      // R9 and R4: window closed after line end, slot before start idle
      step(0, 0, 9, 0, 0, 0, 0, 0, 0, 0, "R9 window cleared at eol");
      step(0, 0, 8, 0, 0, 0, 0, 0, 0, 0, "R4 start slot opens");
      step(0, 0, 9, 0, 0, 0, 1, 3, 0, 0, "R4 fetch after start");
      // R3 plane count
      plane_cnt_i = 3'd2;
      step(0, 0, 10, 0, 0, 0, 0, 0, 0, 0, "R3 plane 5 blocked");
      step(0, 0, 11, 0, 0, 0, 1, 1, 0, 0, "R3 plane 1 allowed");
      step(0, 0, 15, 0, 0, 0, 1, 0, 1, 0, "R10 group on plane 0");
      plane_cnt_i = 3'd6;
      // R5 stop completes the group
      step(1, 5, 300, 0, 0, 0, 0, 0, 0, 1, "R8 modulo second line");
      wr(1, 9);
      step(0, 0, 8,  0, 0, 0, 0, 0, 0, 0, "R5 slot 8");
      step(0, 0, 9,  0, 0, 0, 1, 3, 0, 0, "R5 stop slot fetches");
      step(0, 0, 10, 0, 0, 0, 1, 5, 0, 0, "R5 group continues");
      step(0, 0, 11, 0, 0, 0, 1, 1, 0, 0, "R5 group continues");
      step(0, 0, 12, 0, 0, 0, 0, 0, 0, 0, "R5 skip slot");
      step(0, 0, 13, 0, 0, 0, 1, 2, 0, 0, "R5 group continues");
      step(0, 0, 14, 0, 0, 0, 1, 4, 0, 0, "R5 group continues");
      step(0, 0, 15, 0, 0, 0, 1, 0, 1, 0, "R5 final plane 0");
      step(0, 0, 16, 0, 0, 0, 0, 0, 0, 0, "R5 closed");
      step(0, 0, 17, 0, 0, 0, 0, 0, 0, 0, "R5 closed after group");
      // R7 DMA enable gate
      step(1, 6, 300, 0, 0, 0, 0, 0, 0, 1, "R8 modulo third line");
      dma_en_i = 1'b0;
      step(0, 0, 8, 0, 0, 0, 0, 0, 0, 0, "R7 dma off");
      step(0, 0, 9, 0, 0, 0, 0, 0, 0, 0, "R7 dma off no fetch");
      dma_en_i = 1'b1;
      step(1, 6, 300, 0, 0, 0, 0, 0, 0, 0, "R8 no modulo without fetch");
      // R6 vertical window
      wr(3, 7);
      step(0, 0, 8, 0, 0, 0, 0, 0, 0, 0, "R6 slot 8");
      step(0, 0, 9, 0, 0, 0, 1, 3, 0, 0, "R6 still open line 6");
      step(1, 7, 300, 0, 0, 0, 0, 0, 0, 1, "R6 eol to last line");
      step(0, 0, 8, 0, 0, 0, 0, 0, 0, 0, "R6 slot 8");
      step(0, 0, 9, 0, 0, 0, 0, 0, 0, 0, "R6 closed at last line");
      step(1, 3, 300, 0, 0, 0, 0, 0, 0, 0, "R6 eol to first line");
      step(0, 0, 8, 0, 0, 0, 0, 0, 0, 0, "R6 slot 8");
      step(0, 0, 9, 0, 0, 0, 1, 3, 0, 0, "R6 reopened");
      // R11 write takes effect on the next slot
      step(1, 4, 300, 0, 0, 0, 0, 0, 0, 1, "R8 modulo fourth line");
      step(0, 0, 21, 1, 0, 21, 0, 0, 0, 0, "R11 old start applies");
      step(0, 0, 21, 0, 0, 0, 1, 2, 0, 0, "R11 new start applies");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule